// File: doc/BRIEF.md
# Masked-Write GPIO Bank Register Block

This block holds the pin control state of one 32-pin general-purpose I/O bank. Software reaches it through a simple memory-mapped register bus. It keeps an output data register, a direction register and an output-enable register, and it returns the pin input levels after synchronizing them to the block clock. The pads are modelled as an output value vector and an output-enable vector.

The output data can also be changed through two write-only half-word ports. Each port write carries a 16-bit inverted mask in its upper half and 16 data bits in its lower half. Only the bits whose mask bit is 0 take the new data. Software can therefore set or clear any group of pins in one bus write, with no read-modify-write sequence and no race against other writers of the same register.

Bus timing: a request is a one-cycle pulse of `bus_sel`, with `bus_we` choosing a write or a read. A write takes effect at the clock edge that samples it. Read data appears on `bus_rdata` in the cycle after the request.

Top module: `gpb_bank`

## Requirements
- R1: On synchronous active-low reset the data, direction and output-enable registers clear to 0. `pad_out` and `pad_oe` are then 0 and every register reads back 0.
- R2: A write to byte offset 0x000 (low port) updates data bits 15:0. Word bits 31:16 are the mask and bits 15:0 are the data. Data bit i is loaded only where mask bit i is 0; where the mask bit is 1 the output bit keeps its value. Data bits 31:16 are not changed.
- R3: A write to byte offset 0x004 (high port) applies the same masked rule to data bits 31:16, using word bits 31:16 as the mask and word bits 15:0 as the data. Data bits 15:0 are not changed.
- R4: Offset 0x040 is a full read-write view of the output data register, and `pad_out` always equals that register.
- R5: Offset 0x060 returns `pin_in` through a two-flop synchronizer. A read issued in the cycle after a pin change still returns the old level. A read issued two cycles later returns the new level.
- R6: Offset 0x204 is the read-write direction register: bit value 1 makes the pin an output and 0 makes it an input.
- R7: Offset 0x208 is the read-write output-enable register.
- R8: `pad_oe` bit i is 1 only when both direction bit i and output-enable bit i are 1.
- R9: Reads of the write-only ports (0x000, 0x004) and of unmapped offsets return 0. A write to the read-only offset 0x060 changes no register.
- R10: `bus_rdata` carries the read result in the cycle after a read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Request strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read result, valid the cycle after a read |
| pin_in | input | 32 | Asynchronous pin input levels |
| pad_out | output | 32 | Output value for each pad |
| pad_oe | output | 32 | Pad drive enable, 1 = drive |

## Verification
A table of masked port writes runs from an all-zero state through these cases: mask fully clear, mask fully set (no change), alternating mask bits, nibble-interleaved masks, and writes that change only part of one port. It also alternates between the two ports, so a mask applied to the wrong half, an inverted mask sense or a write that leaks into the other half all give a different `pad_out` value. Directed tests then write direction and output-enable patterns that overlap only in part, so that `pad_oe` shows whether the two are ANDed. They also read the pin register once right after a change and once after the synchronizer has settled, which tells a one-flop path from a two-flop one. Reads of the write-only ports, a write to the read-only register, idle-cycle read data and a reset in the middle of the run cover the remaining corners.

// File: rtl/gpb_pkg.sv
// gpb_pkg: shared offsets and types for the GPIO bank register block.
// Assumes byte addressing with 32-bit registers on a 4-byte stride.
package gpb_pkg;

    // Byte offsets decoded by the block
    localparam int unsigned OFS_PORT_BASE = 'h000;
    localparam int unsigned PORT_STRIDE   = 4;
    localparam int unsigned OFS_DATA      = 'h040;
    localparam int unsigned OFS_PIN       = 'h060;
    localparam int unsigned OFS_DIR       = 'h204;
    localparam int unsigned OFS_OE        = 'h208;

    // Read source selected by the decoder
    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_DATA,
        RSEL_PIN,
        RSEL_DIR,
        RSEL_OE
    } rsel_e;

    // Full-word register write strobes
    typedef struct packed {
        logic data_we;
        logic dir_we;
        logic oe_we;
    } regwr_t;

endpackage

// File: rtl/gpb_sync.sv
// gpb_sync: multi-flop synchronizer for asynchronous pin levels.
// Assumes each bit is an independent level; no bus coherency is needed.
module gpb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // Shift the pin levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpb_decode.sv
// gpb_decode: turns a bus request into write strobes and a read select.
// Assumes full-address compare; anything unmatched reads as none.
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NPORTS = 2
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NPORTS-1:0] port_we,
    output regwr_t            reg_wr,
    output rsel_e             rsel
);

    logic wr_req;
    logic rd_req;

    assign wr_req = bus_sel & bus_we;
    assign rd_req = bus_sel & ~bus_we;

    // One write strobe per masked half-word port
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign port_we[p] = wr_req &
            (bus_addr == ADDR_W'(OFS_PORT_BASE + PORT_STRIDE * p));
    end

    // Full-word write strobes; the pin register has none
    always_comb begin
        reg_wr.data_we = wr_req & (bus_addr == ADDR_W'(OFS_DATA));
        reg_wr.dir_we  = wr_req & (bus_addr == ADDR_W'(OFS_DIR));
        reg_wr.oe_we   = wr_req & (bus_addr == ADDR_W'(OFS_OE));
    end

    // Read source; write-only ports and unmapped offsets give none
    always_comb begin
        rsel = RSEL_NONE;
        if (rd_req) begin
            if      (bus_addr == ADDR_W'(OFS_DATA)) rsel = RSEL_DATA;
            else if (bus_addr == ADDR_W'(OFS_PIN))  rsel = RSEL_PIN;
            else if (bus_addr == ADDR_W'(OFS_DIR))  rsel = RSEL_DIR;
            else if (bus_addr == ADDR_W'(OFS_OE))   rsel = RSEL_OE;
        end
    end

endmodule

// File: rtl/gpb_mask_merge.sv
// gpb_mask_merge: next output data from full-word and masked port writes.
// Assumes the upper half of the write word is an inverted mask (1 = keep).
module gpb_mask_merge #(
    parameter int DATA_W = 32,
    parameter int NPORTS = 2
) (
    input  logic [DATA_W-1:0] cur,
    input  logic              full_we,
    input  logic [DATA_W-1:0] wword,
    input  logic [NPORTS-1:0] port_we,
    output logic [DATA_W-1:0] nxt
);

    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] mask;
    logic [HALF-1:0] val;

    assign mask = wword[DATA_W-1:HALF];
    assign val  = wword[HALF-1:0];

    // Keep masked bits, load the rest of the addressed half
    always_comb begin
        nxt = cur;
        if (full_we) nxt = wword;
        for (int p = 0; p < NPORTS; p++) begin
            if (port_we[p]) begin
                nxt[p*HALF +: HALF] = (cur[p*HALF +: HALF] & mask) | (val & ~mask);
            end
        end
    end

endmodule

// File: rtl/gpb_bank.sv
// gpb_bank: register block for one GPIO bank with masked half-word writes.
// Assumes one-cycle request pulses; read data is registered one cycle later.
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pad_out,
    output logic [DATA_W-1:0] pad_oe
);

    localparam int HALF   = DATA_W / 2;
    localparam int NPORTS = DATA_W / HALF;

    logic [NPORTS-1:0] port_we;
    regwr_t            reg_wr;
    rsel_e             rsel;
    logic [DATA_W-1:0] data_q, dir_q, oe_q, data_nxt, pin_sync;

    gpb_decode #(.ADDR_W(ADDR_W), .NPORTS(NPORTS)) u_decode (
        .bus_sel (bus_sel),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .port_we (port_we),
        .reg_wr  (reg_wr),
        .rsel    (rsel)
    );

    gpb_mask_merge #(.DATA_W(DATA_W), .NPORTS(NPORTS)) u_merge (
        .cur    (data_q),
        .full_we(reg_wr.data_we),
        .wword  (bus_wdata),
        .port_we(port_we),
        .nxt    (data_nxt)
    );

    gpb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_sync)
    );

    // Output data register, loaded from the merge result
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_nxt;
    end

    // Direction and output-enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            oe_q  <= '0;
        end else begin
            if (reg_wr.dir_we) dir_q <= bus_wdata;
            if (reg_wr.oe_we)  oe_q  <= bus_wdata;
        end
    end

    // Registered read data, zero when no read was requested
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            case (rsel)
                RSEL_DATA: bus_rdata <= data_q;
                RSEL_PIN:  bus_rdata <= pin_sync;
                RSEL_DIR:  bus_rdata <= dir_q;
                RSEL_OE:   bus_rdata <= oe_q;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assign pad_out = data_q;
    assign pad_oe  = dir_q & oe_q;

    // R2: low port leaves masked bits and the upper half untouched
    a_r2_low_port_mask: assert property (@(posedge clk) disable iff (!rst_n)
        port_we[0] |=>
            ((data_q[HALF-1:0] & $past(bus_wdata[DATA_W-1:HALF])) ==
             ($past(data_q[HALF-1:0]) & $past(bus_wdata[DATA_W-1:HALF]))) &&
            (data_q[DATA_W-1:HALF] == $past(data_q[DATA_W-1:HALF])));

    // R3: high port loads unmasked bits and leaves the lower half untouched
    a_r3_high_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        port_we[NPORTS-1] |=>
            ((data_q[DATA_W-1:HALF] & ~$past(bus_wdata[DATA_W-1:HALF])) ==
             ($past(bus_wdata[HALF-1:0]) & ~$past(bus_wdata[DATA_W-1:HALF]))) &&
            (data_q[HALF-1:0] == $past(data_q[HALF-1:0])));

    // R6: a direction write is visible on the next cycle
    a_r6_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_DIR)) |=>
            (dir_q == $past(bus_wdata)));

    // R9: a write to the pin register changes nothing
    a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_PIN)) |=>
            ($stable(data_q) && $stable(dir_q) && $stable(oe_q)));

    // R10: read data is zero after a cycle with no read request
    a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_sel && !bus_we) |-> (bus_rdata == '0));

endmodule

// File: tb/gpb_bank_tb.sv
`timescale 1ns/1ps
module gpb_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    gpb_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] word;
        logic [31:0] expect_data;
    } vec_t;

    // Masked port writes from an all-zero data register
    localparam vec_t VECS [7] = '{
        '{12'h000, 32'h0000_A5A5, 32'h0000_A5A5},
        '{12'h004, 32'h0000_1234, 32'h1234_A5A5},
        '{12'h000, 32'hFF00_00FF, 32'h1234_A5FF},
        '{12'h004, 32'h00FF_AB00, 32'hAB34_A5FF},
        '{12'h000, 32'hFFFF_0000, 32'hAB34_A5FF},
        '{12'h004, 32'h5555_0000, 32'h0114_A5FF},
        '{12'h000, 32'h0F0F_F0F0, 32'h0114_F5FF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pad_out after reset", pad_out, 32'h0);
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        bus_read(12'h204, rd); check("R1 dir after reset", rd, 32'h0);
        bus_read(12'h040, rd); check("R1 data after reset", rd, 32'h0);

        // R2/R3: masked port table
        for (int i = 0; i < 7; i++) begin
            bus_write(VECS[i].addr, VECS[i].word);
            if (VECS[i].addr == 12'h000)
                check("R2 low port masked write", pad_out, VECS[i].expect_data);
            else
                check("R3 high port masked write", pad_out, VECS[i].expect_data);
        end
        bus_read(12'h040, rd); check("R4 data reads merged value", rd, 32'h0114_F5FF);

        // R4: full data write
        bus_write(12'h040, 32'hDEAD_BEEF);
        check("R4 pad_out follows data", pad_out, 32'hDEAD_BEEF);
        bus_read(12'h040, rd); check("R4 data readback", rd, 32'hDEAD_BEEF);

        // R6/R7/R8: direction, enable, gating
        bus_write(12'h204, 32'hFFFF_0000);
        bus_read(12'h204, rd); check("R6 dir readback", rd, 32'hFFFF_0000);
        check("R8 pad_oe with oe clear", pad_oe, 32'h0);
        bus_write(12'h208, 32'h0F0F_0F0F);
        bus_read(12'h208, rd); check("R7 oe readback", rd, 32'h0F0F_0F0F);
        check("R8 pad_oe gated", pad_oe, 32'h0F0F_0000);

        // R10: idle cycle after a read gives zero
        @(negedge clk);
        check("R10 idle rdata", bus_rdata, 32'h0);

        // R5: synchronizer latency
        @(negedge clk);
        pin_in = 32'h1357_9BDF;
        bus_read(12'h060, rd); check("R5 pin read too early is old", rd, 32'h0);
        bus_read(12'h060, rd); check("R5 pin read settled", rd, 32'h1357_9BDF);

        // R9: write-only reads, read-only write
        bus_read(12'h000, rd); check("R9 low port reads 0", rd, 32'h0);
        bus_read(12'h004, rd); check("R9 high port reads 0", rd, 32'h0);
        bus_read(12'h100, rd); check("R9 unmapped reads 0", rd, 32'h0);
        bus_write(12'h060, 32'h0000_0000);
        check("R9 ro write keeps pad_out", pad_out, 32'hDEAD_BEEF);
        check("R9 ro write keeps pad_oe", pad_oe, 32'h0F0F_0000);
        bus_read(12'h060, rd); check("R9 pin still reflects input", rd, 32'h1357_9BDF);

        // R1: reset in the middle of the run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 pad_out after mid reset", pad_out, 32'h0);
        check("R1 pad_oe after mid reset", pad_oe, 32'h0);
        bus_read(12'h208, rd); check("R1 oe after mid reset", rd, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule